// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This block is the execution slice of an 8-bit accumulator processor that handles five operations: bitwise inclusive OR, subtract with borrow, rotate left through carry, rotate right through carry and set carry. On each accepted cycle it takes the accumulator, a memory operand, the current condition-code register and an operation code. It returns the new accumulator value and the new condition-code byte.

The arithmetic and flag logic is combinational. A single register stage captures the result, the flags and a valid bit, so the outputs are available one clock after the inputs are accepted. Operand fetch, address decoding and instruction sequencing belong to the surrounding core. When no input is valid, the output registers keep their last contents.

The condition-code byte is laid out from bit 7 down to bit 0 as: overflow V, constant 1, constant 1, half-carry H, interrupt mask I, negative N, zero Z, carry C.

Top module: `acc_rot_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` goes to 0, `res_out` goes to 0x00 and `ccr_out` goes to 0x60.
- R2: A beat accepted with `in_valid` high appears on `res_out`/`ccr_out` with `out_valid` high exactly one clock later. After an edge with `in_valid` low, `out_valid` is 0 and `res_out`/`ccr_out` hold their previous values.
- R3: Op code 0 (OR) gives result A|M and clears V. C keeps its input value.
- R4: Op code 1 (subtract with borrow) gives result (A − M − C) mod 256, using the incoming C. The new C is 1 exactly when M + C is greater than A as unsigned numbers.
- R5: For op code 1, V is (A7 & ~M7 & ~R7) | (~A7 & M7 & R7), where R is the result.
- R6: Op code 2 (rotate left) gives {A[6:0], C_in}. The new C is A7.
- R7: Op code 3 (rotate right) gives {C_in, A[7:1]}. The new C is A0.
- R8: For op codes 2 and 3, the new V is the new N XOR the new C.
- R9: Op code 4 (set carry) sets C to 1, passes A through as the result, and leaves V, H, I, N and Z at their input values.
- R10: For every op code, H (bit 4) and I (bit 3) are copied from the input CCR. Bits 6 and 5 of `ccr_out` always read 1.
- R11: For op codes 0 to 3, N equals result bit 7, and Z is 1 exactly when the result is 0x00.
- R12: Op codes 5 to 7 are reserved. They pass A through as the result and leave every CCR bit at its input value (bits 6 and 5 still read 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat is valid |
| op | input | 3 | Operation code (0 OR, 1 subtract with borrow, 2 rotate left, 3 rotate right, 4 set carry) |
| acc_in | input | 8 | Accumulator operand A |
| mem_in | input | 8 | Memory operand M |
| ccr_in | input | 8 | Current condition-code register |
| out_valid | output | 1 | Registered result is valid |
| res_out | output | 8 | New accumulator value |
| ccr_out | output | 8 | New condition-code register |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- Subtraction with borrow-in where M + C equals or exceeds A, including 0x00 − 0x00 − 1. A design that ignored the incoming carry, or inverted the borrow sense, would return 0x00 with C clear instead of 0xFF with C set.
- Subtraction across the signed boundary (0x80 − 0x01 and 0x7F − 0xFF). This catches an overflow term built from the wrong operand polarity.
- Rotations whose result is zero apart from the carry. A unit that shifted in 0 instead of the old carry, or computed V from the old carry, would report the wrong Z and V.
- Set carry and the reserved codes, fed with CCR bytes that have bits 6 and 5 clear and V, N, Z set. These show whether the unit disturbs bits it must only copy.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [2:0] {
    OP_OR  = 3'd0,
    OP_SBC = 3'd1,
    OP_ROL = 3'd2,
    OP_ROR = 3'd3,
    OP_SEC = 3'd4
  } acr_op_e;

  localparam int CCW   = 8;
  localparam int CC_V  = 7;
  localparam int CC_H  = 4;
  localparam int CC_I  = 3;
  localparam int CC_N  = 2;
  localparam int CC_Z  = 1;
  localparam int CC_C  = 0;
  localparam logic [CCW-1:0] CC_FIXED = 8'h60;
endpackage

// File: rtl/acr_or_unit.sv
module acr_or_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic [W-1:0] r
);
  assign r = a | m;
endmodule

// File: rtl/acr_sub_unit.sv
module acr_sub_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         borrow,
  output logic         ovf
);
  localparam int XW = W + 1;
  logic [XW-1:0] diff;

  assign diff   = {1'b0, a} - {1'b0, m} - {{W{1'b0}}, cin};
  assign r      = diff[W-1:0];
  assign borrow = diff[W];
  assign ovf    = (a[W-1] & ~m[W-1] & ~r[W-1]) | (~a[W-1] & m[W-1] & r[W-1]);
endmodule

// File: rtl/acr_rot_unit.sv
module acr_rot_unit #(
  parameter int W    = 8,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout
);
  generate
    if (LEFT) begin : g_left
      assign r    = {a[W-2:0], cin};
      assign cout = a[W-1];
    end else begin : g_right
      assign r    = {cin, a[W-1:1]};
      assign cout = a[0];
    end
  endgenerate
endmodule

// File: rtl/acc_rot_unit.sv
module acc_rot_unit
  import acr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mem_in,
  input  logic [7:0]   ccr_in,
  output logic         out_valid,
  output logic [W-1:0] res_out,
  output logic [7:0]   ccr_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] or_r, sub_r, rol_r, ror_r;
  logic         sub_b, sub_v, rol_c, ror_c;
  logic         c_in;
  logic [W-1:0] nxt_res;
  logic [7:0]   nxt_ccr;

  assign c_in = ccr_in[CC_C];

  acr_or_unit  #(.W(W)) u_or  (.a(acc_in), .m(mem_in), .r(or_r));
  acr_sub_unit #(.W(W)) u_sub (.a(acc_in), .m(mem_in), .cin(c_in),
                               .r(sub_r), .borrow(sub_b), .ovf(sub_v));
  acr_rot_unit #(.W(W), .LEFT(1'b1)) u_rol (.a(acc_in), .cin(c_in), .r(rol_r), .cout(rol_c));
  acr_rot_unit #(.W(W), .LEFT(1'b0)) u_ror (.a(acc_in), .cin(c_in), .r(ror_r), .cout(ror_c));

  always_comb begin
    nxt_res = acc_in;
    nxt_ccr = ccr_in | CC_FIXED;
    case (op)
      OP_OR: begin
        nxt_res       = or_r;
        nxt_ccr[CC_V] = 1'b0;
      end
      OP_SBC: begin
        nxt_res       = sub_r;
        nxt_ccr[CC_V] = sub_v;
        nxt_ccr[CC_C] = sub_b;
      end
      OP_ROL: begin
        nxt_res       = rol_r;
        nxt_ccr[CC_C] = rol_c;
        nxt_ccr[CC_V] = rol_r[MSB] ^ rol_c;
      end
      OP_ROR: begin
        nxt_res       = ror_r;
        nxt_ccr[CC_C] = ror_c;
        nxt_ccr[CC_V] = ror_r[MSB] ^ ror_c;
      end
      OP_SEC: nxt_ccr[CC_C] = 1'b1;
      default: ;
    endcase
    if (op <= 3'd3) begin
      nxt_ccr[CC_N] = nxt_res[MSB];
      nxt_ccr[CC_Z] = (nxt_res == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_out   <= '0;
      ccr_out   <= CC_FIXED;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out <= nxt_res;
        ccr_out <= nxt_ccr;
      end
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_out) && $stable(ccr_out)));

  assert_or_clears_v_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0) |=> (!ccr_out[CC_V] && res_out == ($past(acc_in) | $past(mem_in))));

  assert_rol_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2) |=> (ccr_out[CC_C] == $past(acc_in[MSB]) && res_out[0] == $past(ccr_in[CC_C])));

  assert_ror_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> (ccr_out[CC_C] == $past(acc_in[0]) && res_out[MSB] == $past(ccr_in[CC_C])));

  assert_sec_only_c_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> (ccr_out[CC_C] && ccr_out[7] == $past(ccr_in[7])
                                  && ccr_out[4:1] == $past(ccr_in[4:1])));

  assert_h_i_kept_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (ccr_out[CC_H] == $past(ccr_in[CC_H]) && ccr_out[CC_I] == $past(ccr_in[CC_I])
                  && ccr_out[6:5] == 2'b11));

  assert_nz_track_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= 3'd3) |=> (ccr_out[CC_N] == res_out[MSB] && ccr_out[CC_Z] == (res_out == '0)));

  assert_reserved_pass_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 3'd5) |=> (res_out == $past(acc_in) && ccr_out == ($past(ccr_in) | CC_FIXED)));
endmodule

// File: tb/acc_rot_unit_bench.sv
module acc_rot_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] acc_in = '0, mem_in = '0, ccr_in = '0;
  logic       out_valid;
  logic [7:0] res_out, ccr_out;

  typedef struct {
    logic [7:0] res;
    logic [7:0] ccr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  logic [7:0] last_res, last_ccr;

  always #2.5 clk = ~clk;

  acc_rot_unit u_acc_rot_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .acc_in(acc_in), .mem_in(mem_in), .ccr_in(ccr_in),
    .out_valid(out_valid), .res_out(res_out), .ccr_out(ccr_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] o, input logic [7:0] a,
                                 input logic [7:0] m, input logic [7:0] cc);
    exp_t e;
    logic [7:0] r;
    logic v, c, n, z;
    int ia, im, ic, d;
    r = a; v = cc[7]; c = cc[0]; n = cc[2]; z = cc[1];
    ia = a; im = m; ic = cc[0];
    case (o)
      3'd0: begin r = a | m; v = 1'b0; e.tag = "R3/R10/R11"; end
      3'd1: begin
        d = ia - im - ic;
        if (d < 0) d = d + 256;
        r = d[7:0];
        c = (im + ic) > ia;
        v = (a[7] & ~m[7] & ~r[7]) | (~a[7] & m[7] & r[7]);
        e.tag = "R4/R5/R10/R11";
      end
      3'd2: begin r = {a[6:0], cc[0]}; c = a[7]; v = r[7] ^ c; e.tag = "R6/R8/R10/R11"; end
      3'd3: begin r = {cc[0], a[7:1]}; c = a[0]; v = r[7] ^ c; e.tag = "R7/R8/R10/R11"; end
      3'd4: begin c = 1'b1; e.tag = "R9/R10"; end
      default: e.tag = "R12";
    endcase
    if (o <= 3'd3) begin n = r[7]; z = (r == 8'h00); end
    e.res = r;
    e.ccr = {v, 1'b1, 1'b1, cc[4], cc[3], n, z, c};
    return e;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [7:0] a,
                       input logic [7:0] m, input logic [7:0] cc);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; acc_in = a; mem_in = m; ccr_in = cc;
    e = model(o, a, m, cc);
    exp_q.push_back(e);
    last_res = e.res; last_ccr = e.ccr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op = 3'd1; acc_in = 8'hA5; mem_in = 8'h5A; ccr_in = 8'h9F;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected out_valid", 8'h01, 8'h00);
        end else begin
          e = exp_q.pop_front();
          chk({e.tag, " result"}, res_out, e.res);
          chk({e.tag, " ccr"}, ccr_out, e.ccr);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R1 res_out", res_out, 8'h00);
    chk("R1 ccr_out", ccr_out, 8'h60);
    @(negedge clk);
    rst = 1'b0;

    // R3 OR corners
    drive(3'd0, 8'h00, 8'h00, 8'h00);
    drive(3'd0, 8'h80, 8'h01, 8'h99);
    // R4/R5 subtract corners
    drive(3'd1, 8'h00, 8'h00, 8'h01);
    drive(3'd1, 8'h80, 8'h01, 8'h00);
    drive(3'd1, 8'h7F, 8'hFF, 8'h00);
    drive(3'd1, 8'h05, 8'h05, 8'h18);
    drive(3'd1, 8'h05, 8'h04, 8'h01);
    // R6/R7/R8 rotate corners
    drive(3'd2, 8'h80, 8'h00, 8'h00);
    drive(3'd2, 8'h40, 8'h00, 8'h01);
    drive(3'd3, 8'h01, 8'h00, 8'h00);
    drive(3'd3, 8'h00, 8'h00, 8'h01);
    // R9 set carry, R12 reserved
    drive(3'd4, 8'h3C, 8'hFF, 8'h00);
    drive(3'd4, 8'h00, 8'h00, 8'h86);
    drive(3'd5, 8'h12, 8'h34, 8'h9E);
    drive(3'd7, 8'h00, 8'hFF, 8'h01);

    // R2: idle hold
    idle(3);
    #1;
    chk("R2 idle out_valid", {7'd0, out_valid}, 8'h00);
    chk("R2 idle res hold", res_out, last_res);
    chk("R2 idle ccr hold", ccr_out, last_ccr);

    // random sweep, both carry values per op
    for (int k = 0; k < 400; k++) begin
      logic [7:0] cc;
      cc = $urandom;
      cc[0] = k[0];
      drive(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), cc);
      if (k % 37 == 0) idle(1);
    end
    idle(4);
    if (exp_q.size() != 0) chk("R2 results missing", 8'(exp_q.size()), 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule